// File: doc/BRIEF.md
# Four-Slot Transmit Descriptor Engine

This block sends frames out of host memory through four transmit slots. Each slot has two 32-bit registers. One holds the byte address of the frame in memory. The other is a command/status word: host software fills it with a length and a start level, and the engine later reports the result in the same word. Writing the command/status word hands the slot to the engine. The engine then reads the frame one byte per granted request from a single memory read port and holds the bytes in a small internal buffer. It streams them out on a valid/ready byte interface, followed by four frame-check placeholder bytes.

Slots are served strictly in turn: 0, 1, 2, 3 and back to 0. The turn moves on only after a frame has been sent in full. If the output side finds the buffer empty partway through a frame, the engine reports an underrun and cuts the frame short. The turn then stays on that slot until software hands it over again. A shared two-bit interrupt status records successes and failures. Software clears it by writing ones. The engine never pads a frame: software supplies at least 60 bytes, and the four trailing placeholder bytes bring the frame to 64.

Top module: `tx_slot_dma_top`

## Requirements
- R1: After reset, every status word reads 0x0000_2000 (only bit 13, host-owned, set). Every address register reads 0, the interrupt status reads 0, `irq` is low and `tx_valid` is low.
- R2: A write to the status word of slot n, at offset 0x10+4n, stores the length from bits 12:0 and the start level from bits 21:16. It clears bits 13, 14, 15, 29, 30 and 31 and queues the slot. Reading the word back gives {thr, 3'b000, len} in those fields until the engine updates it.
- R3: A status write to a slot that is still queued or being sent changes nothing: the stored length, the stored level and the frame that goes out stay as they were.
- R4: A frame sent from address A with length L appears on the byte interface as the memory bytes A to A+L-1, in order, with `tx_fcs` low. Four bytes of value 0 follow with `tx_fcs` high, and `tx_last` is high on the fourth of them. Data is held while `tx_ready` is low, and no padding is added.
- R5: With the engine idle and memory granting every request, the first valid output byte appears exactly T+3 cycles after the clock edge that takes in the status write. T = min(max(32*thr, 1), L, FIFO_DEPTH).
- R6: Bit 13 of the status word rises once all L bytes have been read from memory, even if the output side has not yet taken them. Bit 15 is still clear at that point.
- R7: A frame that completes ends with bits 13 and 15 set and bit 14 clear in its status word. It also sets interrupt status bit 2 and raises `irq`.
- R8: If the output side needs a byte, payload bytes remain and the buffer is empty, the engine ends the frame without `tx_last`. It pulses `tx_abort`, leaves bits 13 and 14 set and bit 15 clear, and sets interrupt status bit 3.
- R9: Slots are served in the order 0, 1, 2, 3, 0. The turn advances only after a completed frame. After an underrun, no other slot is served until the failed slot is queued again.
- R10: The interrupt status is read at offset 0x3C in bits 3:2. Writing ones to those bits clears them, and `irq` is high whenever either bit is set.
- R11: The address register of slot n, at offset 0x20+4n, stores and reads back a full 32-bit value.
- R12: Holding `tx_ready` low while bytes are buffered never causes an underrun. The frame completes normally once `tx_ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | High while any interrupt status bit is set |
| mem_rd_en | output | 1 | Memory byte read request |
| mem_rd_addr | output | 32 | Memory byte address |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rd_data | input | 8 | Read data, valid the cycle after a granted request |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Output side accepts the byte |
| tx_data | output | 8 | Output byte |
| tx_fcs | output | 1 | Byte is a frame-check placeholder |
| tx_last | output | 1 | Final byte of a completed frame |
| tx_abort | output | 1 | One-cycle pulse when a frame is cut by underrun |

## Verification
The bench sweeps every start level from 0 to 3 against four frame lengths across all four slots. In half of the frames the output side accepts only every other cycle. It measures the start latency to the cycle: an off-by-one in the level arithmetic, or ignoring the buffer-depth cap, shows up as a wrong delay or as a frame that never starts.

The bench also holds the output side stalled until the copy is done. This catches an ownership bit that waits for transmit completion, and a busy-slot write that gets through and changes the length. It then withholds memory grants partway through a frame. A design that missed the underrun would stall or send corrupt bytes. A design that advanced the turn after the failure would send the next queued slot early.

// File: rtl/tx_slot_pkg.sv
package tx_slot_pkg;
  localparam int NSLOT = 4;
  localparam logic [7:0] IRQ_OFS = 8'h3C;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FCS, ST_DONE} eng_state_t;

  // Buffered byte count at which output may begin.
  function automatic int start_level(input logic [5:0] thr, input logic [12:0] len,
                                     input int depth);
    int t;
    t = 32 * int'(thr);
    if (t < 1) t = 1;
    if (t > int'(len)) t = int'(len);
    if (t > depth) t = depth;
    return t;
  endfunction

  function automatic logic [31:0] pack_status(input logic [5:0] thr, input logic ok,
                                              input logic unr, input logic own,
                                              input logic [12:0] len);
    return {10'd0, thr, ok, unr, own, len};
  endfunction
endpackage

// File: rtl/tx_byte_fifo.sv
module tx_byte_fifo #(
  parameter int DEPTH = 64,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [7:0]    din,
  input  logic          pop,
  output logic [7:0]    dout,
  output logic [CW-1:0] count
);
  // DEPTH is expected to be a power of two.
  logic [7:0]    store [DEPTH];
  logic [PW-1:0] wp, rp;

  always_ff @(posedge clk) begin
    if (push) store[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign dout = store[rp];
endmodule

// File: rtl/tx_slot_regs.sv
module tx_slot_regs
  import tx_slot_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_we,
  input  logic [7:0]             reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  input  logic [1:0]             cur_slot,
  input  logic                   copy_set,
  input  logic                   done_ok,
  input  logic                   done_err,
  output logic [NSLOT-1:0]       busy,
  output logic [NSLOT-1:0][31:0] slot_addr,
  output logic [NSLOT-1:0][12:0] slot_len,
  output logic [NSLOT-1:0][5:0]  slot_thr,
  output logic [1:0]             irq_stat
);
  logic [NSLOT-1:0] own_q, ok_q, unr_q;
  logic [1:0] wsel;
  logic wr_st, wr_ad, wr_irq;

  assign wsel   = reg_addr[3:2];
  assign wr_st  = reg_we && (reg_addr[7:4] == 4'h1) && (reg_addr[1:0] == 2'b00);
  assign wr_ad  = reg_we && (reg_addr[7:4] == 4'h2) && (reg_addr[1:0] == 2'b00);
  assign wr_irq = reg_we && (reg_addr == IRQ_OFS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= '0; slot_addr <= '0; slot_len <= '0; slot_thr <= '0;
      own_q <= '1; ok_q <= '0; unr_q <= '0; irq_stat <= '0;
    end else begin
      for (int s = 0; s < NSLOT; s++) begin
        if (wr_ad && wsel == 2'(s)) slot_addr[s] <= reg_wdata;
        if (wr_st && wsel == 2'(s) && !busy[s]) begin
          slot_len[s] <= reg_wdata[12:0];
          slot_thr[s] <= reg_wdata[21:16];
          own_q[s] <= 1'b0; ok_q[s] <= 1'b0; unr_q[s] <= 1'b0;
          busy[s] <= 1'b1;
        end
        if (cur_slot == 2'(s)) begin
          if (copy_set) own_q[s] <= 1'b1;
          if (done_ok || done_err) begin
            own_q[s] <= 1'b1;
            ok_q[s]  <= done_ok;
            unr_q[s] <= done_err;
            busy[s]  <= 1'b0;
          end
        end
      end
      irq_stat <= (wr_irq ? (irq_stat & ~reg_wdata[3:2]) : irq_stat) | {done_err, done_ok};
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[1:0] == 2'b00) begin
      case (reg_addr[7:4])
        4'h1: reg_rdata = pack_status(slot_thr[wsel], ok_q[wsel], unr_q[wsel],
                                      own_q[wsel], slot_len[wsel]);
        4'h2: reg_rdata = slot_addr[wsel];
        4'h3: if (reg_addr[3:0] == 4'hC) reg_rdata = {28'd0, irq_stat, 2'b00};
        default: reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/tx_slot_engine.sv
module tx_slot_engine
  import tx_slot_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CW = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSLOT-1:0]       busy,
  input  logic [NSLOT-1:0][31:0] slot_addr,
  input  logic [NSLOT-1:0][12:0] slot_len,
  input  logic [NSLOT-1:0][5:0]  slot_thr,
  output logic                   mem_rd_en,
  output logic [31:0]            mem_rd_addr,
  input  logic                   mem_gnt,
  output logic                   fifo_push,
  output logic                   fifo_pop,
  output logic                   fifo_clr,
  input  logic [7:0]             fifo_dout,
  input  logic [CW-1:0]          fifo_cnt,
  output logic                   tx_valid,
  input  logic                   tx_ready,
  output logic [7:0]             tx_data,
  output logic                   tx_fcs,
  output logic                   tx_last,
  output logic                   tx_abort,
  output logic                   copy_set,
  output logic                   done_ok,
  output logic                   done_err,
  output logic [1:0]             cur_slot
);
  eng_state_t state;
  logic [12:0] len_q, fetched, sent;
  logic [5:0]  thr_q;
  logic [31:0] base_q;
  logic        inflight, started, copied, err_q;
  logic [1:0]  fcs_cnt;
  logic        all_fetched, issue, start_now, pay_valid, underrun, run;

  always_comb begin
    run         = (state == ST_RUN);
    all_fetched = (fetched == len_q);
    issue       = run && !all_fetched && (int'(fifo_cnt) + int'(inflight) < DEPTH);
    start_now   = run && !started && (int'(fifo_cnt) >= start_level(thr_q, len_q, DEPTH));
    pay_valid   = run && started && (sent != len_q) && (fifo_cnt != '0);
    underrun    = run && started && (sent != len_q) && (fifo_cnt == '0);
  end

  assign mem_rd_en   = issue;
  assign mem_rd_addr = base_q + {19'd0, fetched};
  assign fifo_push   = run && inflight;
  assign fifo_pop    = pay_valid && tx_ready;
  assign fifo_clr    = (state == ST_DONE);
  assign tx_valid    = pay_valid || (state == ST_FCS);
  assign tx_fcs      = (state == ST_FCS);
  assign tx_data     = tx_fcs ? 8'h00 : fifo_dout;
  assign tx_last     = tx_fcs && (fcs_cnt == 2'd3);
  assign copy_set    = run && !copied && all_fetched && !inflight;
  assign done_ok     = (state == ST_DONE) && !err_q;
  assign done_err    = (state == ST_DONE) && err_q;
  assign tx_abort    = done_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; cur_slot <= '0; len_q <= '0; thr_q <= '0; base_q <= '0;
      fetched <= '0; sent <= '0; inflight <= 1'b0; started <= 1'b0;
      copied <= 1'b0; err_q <= 1'b0; fcs_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (busy[cur_slot]) begin
          len_q <= slot_len[cur_slot]; thr_q <= slot_thr[cur_slot];
          base_q <= slot_addr[cur_slot];
          fetched <= '0; sent <= '0; inflight <= 1'b0; started <= 1'b0;
          copied <= 1'b0; err_q <= 1'b0; fcs_cnt <= '0;
          state <= ST_RUN;
        end
        ST_RUN: begin
          inflight <= issue && mem_gnt;
          if (issue && mem_gnt) fetched <= fetched + 1'b1;
          if (start_now) started <= 1'b1;
          if (fifo_pop) sent <= sent + 1'b1;
          if (copy_set) copied <= 1'b1;
          if (underrun) begin
            err_q <= 1'b1;
            state <= ST_DONE;
          end else if (started && sent == len_q) begin
            state <= ST_FCS;
          end
        end
        ST_FCS: if (tx_ready) begin
          if (fcs_cnt == 2'd3) state <= ST_DONE;
          else fcs_cnt <= fcs_cnt + 1'b1;
        end
        default: begin
          if (!err_q) cur_slot <= cur_slot + 1'b1;
          inflight <= 1'b0;
          state <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/tx_slot_dma_top.sv
module tx_slot_dma_top
  import tx_slot_pkg::*;
#(
  parameter int FIFO_DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        mem_rd_en,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_gnt,
  input  logic [7:0]  mem_rd_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_fcs,
  output logic        tx_last,
  output logic        tx_abort
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  logic [NSLOT-1:0]       busy;
  logic [NSLOT-1:0][31:0] slot_addr;
  logic [NSLOT-1:0][12:0] slot_len;
  logic [NSLOT-1:0][5:0]  slot_thr;
  logic [1:0]             irq_stat, cur_slot;
  logic                   copy_set, done_ok, done_err;
  logic                   fifo_push, fifo_pop, fifo_clr;
  logic [7:0]             fifo_dout;
  logic [CW-1:0]          fifo_cnt;

  tx_slot_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cur_slot(cur_slot),
    .copy_set(copy_set), .done_ok(done_ok), .done_err(done_err), .busy(busy),
    .slot_addr(slot_addr), .slot_len(slot_len), .slot_thr(slot_thr),
    .irq_stat(irq_stat)
  );

  tx_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .push(fifo_push), .din(mem_rd_data),
    .pop(fifo_pop), .dout(fifo_dout), .count(fifo_cnt)
  );

  tx_slot_engine #(.DEPTH(FIFO_DEPTH), .CW(CW)) u_eng (
    .clk(clk), .rst_n(rst_n), .busy(busy), .slot_addr(slot_addr),
    .slot_len(slot_len), .slot_thr(slot_thr), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_gnt(mem_gnt), .fifo_push(fifo_push),
    .fifo_pop(fifo_pop), .fifo_clr(fifo_clr), .fifo_dout(fifo_dout),
    .fifo_cnt(fifo_cnt), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_fcs(tx_fcs), .tx_last(tx_last), .tx_abort(tx_abort),
    .copy_set(copy_set), .done_ok(done_ok), .done_err(done_err),
    .cur_slot(cur_slot)
  );

  assign irq = |irq_stat;
endmodule

// File: rtl/tx_slot_chk.sv
module tx_slot_chk #(
  parameter int DEPTH = 64,
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          tx_fcs,
  input logic          tx_last,
  input logic          tx_abort,
  input logic          done_ok,
  input logic          done_err,
  input logic [1:0]    cur_slot,
  input logic [CW-1:0] fifo_cnt,
  input logic [1:0]    irq_stat
);
  a_r4_last_is_fcs: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> (tx_valid && tx_fcs));
  a_r4_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_fcs)));
  a_r7_ok_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |=> irq_stat[0]);
  a_r8_err_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |=> irq_stat[1]);
  a_r8_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> !tx_valid);
  a_r9_advance_on_ok: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |=> (cur_slot == $past(cur_slot) + 2'd1));
  a_r9_hold_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |=> $stable(cur_slot));
  a_r9_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_ok, done_err}));
  a_r12_fifo_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifo_cnt) <= DEPTH);
endmodule

bind tx_slot_dma_top tx_slot_chk #(.DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_fcs(tx_fcs), .tx_last(tx_last), .tx_abort(tx_abort),
  .done_ok(done_ok), .done_err(done_err), .cur_slot(cur_slot),
  .fifo_cnt(fifo_cnt), .irq_stat(irq_stat)
);

// File: tb/sim_tx_slot_dma_top.sv
`timescale 1ns/100ps
module sim_tx_slot_dma_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, mem_rd_en, mem_gnt = 1'b1;
  logic [31:0] mem_rd_addr;
  logic [7:0]  mem_rd_data = '0;
  logic        tx_valid, tx_ready = 1'b1, tx_fcs, tx_last, tx_abort;
  logic [7:0]  tx_data;

  int n_chk = 0, n_bad = 0, cyc = 0, wcyc = 0, first_cyc = 0;
  bit arm = 0, toggle_mode = 0, hold_ready = 0;
  int idx = 0, fcs = 0, bad = 0, frames = 0, aborts = 0, fptr = 0, qw = 0;
  logic [31:0] exp_base [32];
  int          exp_len  [32];

  tx_slot_dma_top u0 (.*);

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  always @(posedge clk) if (mem_rd_en && mem_gnt) mem_rd_data <= pat(mem_rd_addr);

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // output-side ready driver
  initial forever begin
    @(posedge clk); #1;
    if (hold_ready) tx_ready = 1'b0;
    else if (toggle_mode) tx_ready = ~tx_ready;
    else tx_ready = 1'b1;
  end

  // byte monitor (R4)
  always @(negedge clk) if (rst_n) begin
    if (arm && tx_valid) begin first_cyc = cyc; arm = 0; end
    if (tx_abort) begin
      aborts++; idx = 0; fcs = 0; bad = 0; fptr++;
    end else if (tx_valid && tx_ready) begin
      if (!tx_fcs) begin
        if (tx_data != pat(exp_base[fptr] + 32'(idx))) bad++;
        idx++;
      end else begin
        fcs++;
        if (tx_data != 8'h00) bad++;
      end
      if (tx_last) begin
        chk(bad == 0 && idx == exp_len[fptr] && fcs == 4, "R4 frame content",
            32'(idx), 32'(exp_len[fptr]));
        frames++; fptr++; idx = 0; fcs = 0; bad = 0;
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
    wcyc = cyc;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic expect_frame(input logic [31:0] b, input int l);
    exp_base[qw] = b; exp_len[qw] = l; qw++;
  endtask

  task automatic send(input int s, input logic [31:0] b, input int l, input int thr);
    wr(8'(8'h20 + 4 * s), b);
    arm = 1;
    wr(8'(8'h10 + 4 * s), {10'd0, 6'(thr), 3'b000, 13'(l)});
  endtask

  task automatic wait_done(input int s, output logic [31:0] w);
    w = '0;
    for (int k = 0; k < 4000; k++) begin
      rd(8'(8'h10 + 4 * s), w);
      if (w[15] || w[14]) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] w;
    int lens [4] = '{60, 61, 77, 128};
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    for (int s = 0; s < 4; s++) begin
      rd(8'(8'h10 + 4 * s), w); chk(w == 32'h2000, "R1 status reset", w, 32'h2000);
      rd(8'(8'h20 + 4 * s), w); chk(w == 0, "R1 addr reset", w, 0);
    end
    rd(8'h3C, w); chk(w == 0 && !irq && !tx_valid, "R1 irq/tx idle", w, 0);

    // R11: address registers
    for (int s = 0; s < 4; s++) wr(8'(8'h20 + 4 * s), 32'hC0DE_0000 + 32'(s * 3 + 1));
    for (int s = 0; s < 4; s++) begin
      rd(8'(8'h20 + 4 * s), w);
      chk(w == 32'hC0DE_0000 + 32'(s * 3 + 1), "R11 addr readback", w,
          32'hC0DE_0000 + 32'(s * 3 + 1));
    end

    // Sweep: R2 R4 R5 R7 R9 R10
    for (int t = 0; t < 4; t++) begin
      for (int l = 0; l < 4; l++) begin
        int n, lvl;
        logic [31:0] b;
        n = t * 4 + l;
        b = 32'h1000 * 32'(n + 1) + 32'(n * 7);
        toggle_mode = (n % 2 == 1);
        lvl = (t == 0) ? 1 : t * 32;
        if (lens[l] < lvl) lvl = lens[l];
        if (64 < lvl) lvl = 64;
        expect_frame(b, lens[l]);
        send(l, b, lens[l], t);
        rd(8'(8'h10 + 4 * l), w);
        chk(w == {10'd0, 6'(t), 3'b000, 13'(lens[l])}, "R2 status after write", w,
            {10'd0, 6'(t), 3'b000, 13'(lens[l])});
        wait_done(l, w);
        chk(w == ({10'd0, 6'(t), 16'h0000} | 32'hA000 | 32'(lens[l])), "R7 R9 status ok",
            w, {10'd0, 6'(t), 16'h0000} | 32'hA000 | 32'(lens[l]));
        chk(first_cyc - wcyc == lvl + 3, "R5 start latency", 32'(first_cyc - wcyc),
            32'(lvl + 3));
        rd(8'h3C, w); chk(w == 32'h4 && irq, "R7 irq bit2", w, 32'h4);
        wr(8'h3C, 32'h4);
        rd(8'h3C, w); chk(w == 0 && !irq, "R10 clear bit2", w, 0);
      end
    end
    toggle_mode = 0;
    chk(frames == 16, "R9 frames in sweep", 32'(frames), 16);

    // R6 R3 R12: output held off while copy completes
    hold_ready = 1;
    expect_frame(32'h0004_2000, 60);
    send(0, 32'h0004_2000, 60, 0);
    w = '0;
    for (int k = 0; k < 500; k++) begin
      rd(8'h10, w);
      if (w[13]) break;
    end
    chk(w[13] && !w[15], "R6 owned after copy", w, 32'h2000 | 60);
    wr(8'h10, 32'd90);
    rd(8'h10, w);
    chk(w[12:0] == 13'd60 && !w[15], "R3 busy write ignored", w, 32'h2000 | 60);
    repeat (20) @(posedge clk);
    hold_ready = 0;
    wait_done(0, w);
    chk(w == (32'hA000 | 60), "R12 stall then complete", w, 32'hA000 | 60);
    chk(aborts == 0, "R12 no underrun while stalled", 32'(aborts), 0);
    wr(8'h3C, 32'h4);

    // R8: underrun on slot 1
    expect_frame(32'h0005_0100, 100);
    send(1, 32'h0005_0100, 100, 0);
    for (int k = 0; k < 200 && arm; k++) @(posedge clk);
    repeat (5) @(posedge clk);
    #1 mem_gnt = 1'b0;
    repeat (3) @(posedge clk);
    #1 mem_gnt = 1'b1;
    wait_done(1, w);
    chk(w == (32'h6000 | 100), "R8 underrun status", w, 32'h6000 | 100);
    rd(8'h3C, w); chk(w == 32'h8 && irq, "R8 irq bit3", w, 32'h8);
    chk(aborts == 1, "R8 abort pulse", 32'(aborts), 1);
    wr(8'h3C, 32'h8);

    // R9: turn stays on the failed slot
    wr(8'h28, 32'h0006_0300);
    wr(8'h18, 32'd60);
    repeat (100) @(posedge clk);
    chk(frames == 17, "R9 no skip past failed slot", 32'(frames), 17);
    rd(8'h18, w); chk(w == 32'd60, "R9 slot2 untouched", w, 32'd60);
    expect_frame(32'h0007_0200, 64);
    expect_frame(32'h0006_0300, 60);
    send(1, 32'h0007_0200, 64, 1);
    wait_done(1, w); chk(w == (32'h0001_A000 | 64), "R9 slot1 retry ok", w, 32'h0001_A000 | 64);
    wait_done(2, w); chk(w == (32'hA000 | 60), "R9 slot2 after retry", w, 32'hA000 | 60);
    chk(frames == 19, "R9 final frame count", 32'(frames), 19);

    // R10: write-one-to-clear per bit
    wr(8'h3C, 32'h8);
    rd(8'h3C, w); chk(w == 32'h4 && irq, "R10 bit3 write keeps bit2", w, 32'h4);
    wr(8'h3C, 32'h4);
    rd(8'h3C, w); chk(w == 0 && !irq, "R10 bit2 cleared", w, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule